// File: doc/BRIEF.md
# Two-Bit Min-Sum Check Node Processor

This block is the check-node stage of a low-density parity-check decoder that uses two-bit messages. Each variable-to-check message carries a hard-decision sign and a single confidence bit. For one parity equation, the block takes all 32 incoming messages in a single beat. It produces a 3-bit summary: the parity of all signs, a flag that every input is confident, and a flag that at most one input is not confident. A later stage rebuilds the per-edge check-to-variable messages from this summary.

A magnitude is only one bit wide, so the two minimum flags need no comparators. They are threshold-count functions. Each group of four bits yields a "three or more high" term and an "all high" term. Two such quads form an 8-input group. The block has four groups, and the second pipeline stage merges their results with the same rule. The sign parity comes from a balanced tree of 2-input XOR gates. One register stage follows the group logic and one follows the merge, and a valid flag travels alongside the data.

Top module: `tbmsa_check_node`

## Requirements
- R1: Message i sits in in_msg[2i+1:2i]. Bit 2i+1 is its sign (1 means negative) and bit 2i is its confidence bit (1 means high confidence).
- R2: For each accepted beat, out_sign equals the XOR of the 32 sign bits.
- R3: For each accepted beat, out_min1 is 1 exactly when all 32 confidence bits are 1.
- R4: For each accepted beat, out_min2 is 1 exactly when no more than one confidence bit is 0.
- R5: A beat is accepted on a rising edge with in_valid high. Its result appears with out_valid high after the second rising edge from then.
- R6: out_valid is high for exactly one cycle per accepted beat, and beats on consecutive cycles produce results on consecutive cycles.
- R7: While no result is being delivered, out_sign, out_min1 and out_min2 keep their last values. Changes on in_msg while in_valid is low have no effect on the outputs.
- R8: While rst_n is low, out_valid, out_sign, out_min1 and out_min2 are all 0.
- R9: out_min1 high always comes with out_min2 high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | in_msg holds a beat to process |
| in_msg | input | 64 | 32 two-bit messages, packed {sign, confidence} |
| out_valid | output | 1 | A result is on the outputs this cycle |
| out_sign | output | 1 | Parity of all input signs |
| out_min1 | output | 1 | Every confidence bit was high |
| out_min2 | output | 1 | At most one confidence bit was low |

## Verification
The bench targets the region around the min2 threshold. It drives every single-zero pattern and every double-zero pattern, which covers pairs inside one quad, across the two quads of a group, and across groups. A merge that used a 2-of-4 rule, or that ignored the cross-group count, would raise min2 for two lows in different groups. A quad term with a missing product would drop min2 for one low at that lane. Random beats with idle gaps, garbage on in_msg while idle, and back-to-back streaming expose a wrong latency, a stretched valid, and outputs that change while no result is due.

// File: rtl/tbmsa_pkg.sv
package tbmsa_pkg;
  localparam int MSG_W = 2;
  localparam int QUAD  = 4;

  // true when at least three of four bits are high
  function automatic logic three_of_four(input logic [3:0] x);
    return (x[0] & x[1] & (x[2] | x[3])) | ((x[0] | x[1]) & x[2] & x[3]);
  endfunction
endpackage

// File: rtl/tbmsa_quad_term.sv
module tbmsa_quad_term
  import tbmsa_pkg::*;
(
  input  logic [QUAD-1:0] mag,
  output logic            hi3,
  output logic            hi4
);
  always_comb begin
    hi3 = three_of_four(mag);
    hi4 = &mag;
  end
endmodule

// File: rtl/tbmsa_group8.sv
module tbmsa_group8
  import tbmsa_pkg::*;
(
  input  logic [2*QUAD-1:0] mag,
  output logic              grp_min1,
  output logic              grp_min2
);
  logic lo_hi3, lo_hi4, up_hi3, up_hi4;

  tbmsa_quad_term u_lo (.mag(mag[QUAD-1:0]),      .hi3(lo_hi3), .hi4(lo_hi4));
  tbmsa_quad_term u_up (.mag(mag[2*QUAD-1:QUAD]), .hi3(up_hi3), .hi4(up_hi4));

  always_comb begin
    grp_min1 = lo_hi4 & up_hi4;
    grp_min2 = (lo_hi3 & up_hi3 & (lo_hi4 | up_hi4)) | ((lo_hi3 | up_hi3) & lo_hi4 & up_hi4);
  end

  always_comb begin
    AST_GRP_MIN_ORDER: assert (!grp_min1 || grp_min2); // R9
  end
endmodule

// File: rtl/tbmsa_sign_tree.sv
module tbmsa_sign_tree #(
  parameter int N = 32
) (
  input  logic [N-1:0] bits,
  output logic         parity
);
  localparam int NODES = 2*N - 1;
  logic [NODES-1:0] node;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_leaf
      assign node[N-1+gi] = bits[gi];
    end
    for (gi = 0; gi < N-1; gi++) begin : g_xor
      assign node[gi] = node[2*gi+1] ^ node[2*gi+2];
    end
  endgenerate

  assign parity = node[0];
endmodule

// File: rtl/tbmsa_check_node.sv
module tbmsa_check_node
  import tbmsa_pkg::*;
#(
  parameter int NUM_MSG    = 32,
  parameter int GROUP_SIZE = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [NUM_MSG*MSG_W-1:0] in_msg,
  output logic                     out_valid,
  output logic                     out_sign,
  output logic                     out_min1,
  output logic                     out_min2
);
  localparam int NUM_GROUPS = NUM_MSG / GROUP_SIZE; // merge rule built for four groups

  logic [NUM_MSG-1:0]    sgn_vec, mag_vec;
  logic [NUM_GROUPS-1:0] grp_m1, grp_m2;
  logic                  parity;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_MSG; gi++) begin : g_split
      assign sgn_vec[gi] = in_msg[MSG_W*gi+1];
      assign mag_vec[gi] = in_msg[MSG_W*gi];
    end
    for (gi = 0; gi < NUM_GROUPS; gi++) begin : g_grp
      tbmsa_group8 u_grp (
        .mag      (mag_vec[gi*GROUP_SIZE +: GROUP_SIZE]),
        .grp_min1 (grp_m1[gi]),
        .grp_min2 (grp_m2[gi])
      );
    end
  endgenerate

  tbmsa_sign_tree #(.N(NUM_MSG)) u_sgn (.bits(sgn_vec), .parity(parity));

  // stage 1 registers
  logic                  v1_q;
  logic                  sgn1_q, sgn1_d;
  logic [NUM_GROUPS-1:0] m1_q, m1_d, m2_q, m2_d;

  always_comb begin
    sgn1_d = sgn1_q;
    m1_d   = m1_q;
    m2_d   = m2_q;
    if (in_valid) begin
      sgn1_d = parity;
      m1_d   = grp_m1;
      m2_d   = grp_m2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q   <= 1'b0;
      sgn1_q <= 1'b0;
      m1_q   <= '0;
      m2_q   <= '0;
    end else begin
      v1_q   <= in_valid;
      sgn1_q <= sgn1_d;
      m1_q   <= m1_d;
      m2_q   <= m2_d;
    end
  end

  // stage 2: merge the groups with the same threshold structure
  logic sgn_d, min1_d, min2_d;

  always_comb begin
    sgn_d  = out_sign;
    min1_d = out_min1;
    min2_d = out_min2;
    if (v1_q) begin
      sgn_d  = sgn1_q;
      min1_d = &m1_q;
      min2_d = (&m2_q) & three_of_four(m1_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sign  <= 1'b0;
      out_min1  <= 1'b0;
      out_min2  <= 1'b0;
    end else begin
      out_valid <= v1_q;
      out_sign  <= sgn_d;
      out_min1  <= min1_d;
      out_min2  <= min2_d;
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid); // R5
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !v1_q |=> !out_valid); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !v1_q |=> $stable({out_sign, out_min1, out_min2})); // R7
  AST_SIGN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 (out_sign == $past(^sgn_vec, 2))); // R2
  AST_MIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    out_min1 |-> out_min2); // R9
endmodule

// File: tb/tbmsa_check_node_tb_top.sv
module tbmsa_check_node_tb_top;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [2*N-1:0] in_msg = '0;
  logic          out_valid, out_sign, out_min1, out_min2;

  int checks = 0;
  int errors = 0;

  // bench model state: expected results for the two beats in flight
  logic       pv0 = 1'b0, pv1 = 1'b0;
  logic [2:0] pe0 = '0, pe1 = '0;
  logic [2:0] held = '0;

  always #2 clk = ~clk;

  tbmsa_check_node dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_msg(in_msg),
    .out_valid(out_valid), .out_sign(out_sign), .out_min1(out_min1), .out_min2(out_min2)
  );

  function automatic logic [2:0] ref_result(input logic [2*N-1:0] m);
    int zeros = 0;
    logic s = 1'b0;
    for (int i = 0; i < N; i++) begin
      s = s ^ m[2*i+1];
      if (!m[2*i]) zeros++;
    end
    return {s, zeros == 0, zeros <= 1};
  endfunction

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic [2*N-1:0] m);
    @(negedge clk);
    chk("R5/R6 valid", {2'b0, out_valid}, {2'b0, pv1});
    if (pv1) begin
      chk("R2 sign", {2'b0, out_sign}, {2'b0, pe1[2]});
      chk("R3 min1", {2'b0, out_min1}, {2'b0, pe1[1]});
      chk("R4 min2", {2'b0, out_min2}, {2'b0, pe1[0]});
      held = pe1;
    end else begin
      chk("R7 hold", {out_sign, out_min1, out_min2}, held);
    end
    pv1 = pv0; pe1 = pe0;
    pv0 = v;   pe0 = ref_result(m);
    in_valid = v;
    in_msg   = m;
  endtask

  function automatic logic [2*N-1:0] all_conf(input logic [N-1:0] signs);
    logic [2*N-1:0] m;
    for (int i = 0; i < N; i++) m[2*i+1 -: 2] = {signs[i], 1'b1};
    return m;
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2*N-1:0] m;
    void'($urandom(32'h1badc0de));
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 reset", {out_sign, out_min1, out_min2}, 3'b000);
    chk("R8 reset valid", {2'b0, out_valid}, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;

    // directed: all confident, all unconfident, signs patterns (R1)
    step(1'b1, all_conf('0));
    step(1'b1, all_conf('1));
    step(1'b1, '0);
    step(1'b1, {N{2'b10}});
    step(1'b1, all_conf(32'h0000_0001));
    // every single-zero pattern (R4 boundary)
    for (int i = 0; i < N; i++) begin
      m = all_conf($urandom());
      m[2*i] = 1'b0;
      step(1'b1, m);
    end
    // every double-zero pattern (R4 above boundary)
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++) begin
        m = all_conf($urandom());
        m[2*i] = 1'b0;
        m[2*j] = 1'b0;
        step(1'b1, m);
      end
    // idle with garbage on in_msg (R7)
    repeat (6) step(1'b0, {$urandom(), $urandom()});
    // random traffic with gaps, biased toward confident bits
    for (int k = 0; k < 3000; k++) begin
      m = {$urandom(), $urandom()};
      if (k % 2 == 0) m = m | {N{2'b01}};
      if (k % 4 == 1) m[2*($urandom() % N)] = 1'b0;
      step(($urandom() % 4) != 0, m);
    end
    repeat (4) step(1'b0, {$urandom(), $urandom()});
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule